// File: doc/BRIEF.md
# Dual-Mode Timer/Counter Channel

This block is one timer/counter channel of the kind found in small microcontrollers. It keeps its count in two byte registers and counts in one of two widths. In the 13-bit width the count is made of the whole high byte above the lowest five bits of the low byte. In the 16-bit width both bytes are used in full. The increment source is either every system clock cycle (timer use) or each falling transition on an external count pin (event-counter use). A gate option lets an active-low interrupt pin hold counting off while that pin is low.

When the count wraps from all ones to zero, the channel sets an overflow flag and raises a single-cycle pulse on a dedicated output. The flag is cleared when the processor acknowledges the interrupt vector. Software can also write the flag directly, and it can load either count byte at any time. The external count pin and the gate pin are asynchronous. Each passes through a synchronizer inside the block.

Top module: `dual_mode_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `cnt_lo`, `cnt_hi`, `ovf_flag` and `ovf_pulse` all become 0.
- R2: With `run_en`=1, `src_ext`=0, the gate open and no byte write, the count rises by exactly one on every clock edge.
- R3: With `run_en`=0 and no byte write, `cnt_lo` and `cnt_hi` hold their values.
- R4: With `src_ext`=1, the count rises by one for each 1-to-0 transition of `cnt_pin`, and each transition counts once. Transitions from 0 to 1, steady levels and the clock itself add nothing. The pin passes through a two-flop synchronizer and an edge flop, so a transition is counted at the third clock edge after it.
- R5: With `gate_en`=1, counting stops while `irq_n` is 0 and proceeds while `irq_n` is 1. With `gate_en`=0, `irq_n` has no effect. `irq_n` is synchronized through two flops.
- R6: With `wide_mode`=0, the count is {`cnt_hi`, `cnt_lo[4:0]`}, and it wraps from 0x1FFF to 0. Counting never alters `cnt_lo[7:5]`.
- R7: With `wide_mode`=1, the count is {`cnt_hi`, `cnt_lo`}. A carry from `cnt_lo`=0xFF increments `cnt_hi`, and the count wraps from 0xFFFF to 0.
- R8: A wrap sets `ovf_flag` and raises `ovf_pulse` for exactly one cycle. Both outputs change at the same edge that loads the zero count.
- R9: `vec_ack`=1 clears `ovf_flag`. If a wrap happens in the same cycle, the flag is set instead.
- R10: `flag_we`=1 loads `flag_wdata` into `ovf_flag`. This takes priority over both a wrap and `vec_ack` in the same cycle. The pulse still occurs on a wrap.
- R11: `lo_we` or `hi_we` loads the matching byte from its write data. Any byte write cancels that cycle's increment, so an unwritten byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counting enable |
| src_ext | input | 1 | 0: count clock cycles, 1: count falling edges of `cnt_pin` |
| gate_en | input | 1 | 1: `irq_n` low holds counting off |
| irq_n | input | 1 | Asynchronous active-low interrupt pin used as gate |
| cnt_pin | input | 1 | Asynchronous external count pin |
| wide_mode | input | 1 | 0: 13-bit count, 1: 16-bit count |
| lo_we | input | 1 | Write strobe for the low byte |
| lo_wdata | input | 8 | Low byte write data |
| hi_we | input | 1 | Write strobe for the high byte |
| hi_wdata | input | 8 | High byte write data |
| flag_we | input | 1 | Write strobe for the overflow flag |
| flag_wdata | input | 1 | Overflow flag write data |
| vec_ack | input | 1 | Interrupt vector acknowledge, clears the flag |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Overflow flag |
| ovf_pulse | output | 1 | One-cycle wrap pulse |

## Verification
The assertions assume that `wide_mode` only changes when the block is not counting. If it changed while counting, the wrap point would move and a zero count could appear without a pulse. The bench follows this rule and switches width only while `run_en` is low. The properties on `cnt_pin` and `irq_n` cover only what these pins cause after their synchronizers, because the pins themselves are asynchronous. To keep that synchronizer latency out of the expected values, the bench changes `irq_n` only while `run_en` is low, and it lets the pin settle before it compares counts. The bench checks event counting by comparing the total number of pin falls against the count after a settling gap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    SRC_CLK = 1'b0,
    SRC_PIN = 1'b1
  } src_e;

  typedef enum logic {
    WIDTH_NARROW = 1'b0,
    WIDTH_FULL   = 1'b1
  } width_e;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int       STAGES = 2,
  parameter logic     INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= INIT;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= INIT;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  src_e src_sel,
  input  logic gate_en,
  input  logic irq_sync,
  input  logic pin_sync,
  output logic tick
);
  logic pin_prev;
  logic pin_fall;
  logic gate_open;

  always_ff @(posedge clk) begin
    if (rst) pin_prev <= 1'b1;
    else     pin_prev <= pin_sync;
  end

  assign pin_fall  = pin_prev & ~pin_sync;
  assign gate_open = ~gate_en | irq_sync;

  always_comb begin
    tick = 1'b0;
    if (run_en && gate_open) begin
      if (src_sel == SRC_PIN) tick = pin_fall;
      else                    tick = 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int NARROW_LO_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  width_e            width,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] lo_wdata,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] hi_wdata,
  input  logic              flag_we,
  input  logic              flag_wdata,
  input  logic              vec_ack,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_flag,
  output logic              ovf_pulse
);
  localparam int WIDE_W   = 2 * BYTE_W;
  localparam int NARROW_W = BYTE_W + NARROW_LO_BITS;

  logic                any_we;
  logic                step;
  logic                at_top;
  logic                wrap;
  logic [WIDE_W-1:0]   wide_val;
  logic [WIDE_W-1:0]   wide_inc;
  logic [NARROW_W-1:0] narrow_val;
  logic [NARROW_W-1:0] narrow_inc;
  logic [BYTE_W-1:0]   lo_next;
  logic [BYTE_W-1:0]   hi_next;

  assign any_we     = lo_we | hi_we;
  assign step       = tick & ~any_we;
  assign wide_val   = {cnt_hi, cnt_lo};
  assign narrow_val = {cnt_hi, cnt_lo[NARROW_LO_BITS-1:0]};
  assign wide_inc   = wide_val + WIDE_W'(1);
  assign narrow_inc = narrow_val + NARROW_W'(1);

  always_comb begin
    if (width == WIDTH_FULL) begin
      at_top  = &wide_val;
      lo_next = wide_inc[BYTE_W-1:0];
      hi_next = wide_inc[WIDE_W-1:BYTE_W];
    end else begin
      at_top  = &narrow_val;
      lo_next = {cnt_lo[BYTE_W-1:NARROW_LO_BITS], narrow_inc[NARROW_LO_BITS-1:0]};
      hi_next = narrow_inc[NARROW_W-1:NARROW_LO_BITS];
    end
  end

  assign wrap = step & at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (any_we) begin
      if (lo_we) cnt_lo <= lo_wdata;
      if (hi_we) cnt_hi <= hi_wdata;
    end else if (step) begin
      cnt_lo <= lo_next;
      cnt_hi <= hi_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_pulse <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      ovf_pulse <= wrap;
      if (flag_we)      ovf_flag <= flag_wdata;
      else if (wrap)    ovf_flag <= 1'b1;
      else if (vec_ack) ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import tmr_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int NARROW_LO_BITS = 5,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              src_ext,
  input  logic              gate_en,
  input  logic              irq_n,
  input  logic              cnt_pin,
  input  logic              wide_mode,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] lo_wdata,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] hi_wdata,
  input  logic              flag_we,
  input  logic              flag_wdata,
  input  logic              vec_ack,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_flag,
  output logic              ovf_pulse
);
  logic   irq_s;
  logic   pin_s;
  logic   tick;
  src_e   src_sel;
  width_e width;

  assign src_sel = src_e'(src_ext);
  assign width   = width_e'(wide_mode);

  tmr_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) i_irq_sync (
    .clk(clk), .rst(rst), .din(irq_n), .dout(irq_s)
  );

  tmr_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) i_pin_sync (
    .clk(clk), .rst(rst), .din(cnt_pin), .dout(pin_s)
  );

  tmr_tick_gen i_tick (
    .clk(clk), .rst(rst), .run_en(run_en), .src_sel(src_sel),
    .gate_en(gate_en), .irq_sync(irq_s), .pin_sync(pin_s), .tick(tick)
  );

  tmr_count_core #(.BYTE_W(BYTE_W), .NARROW_LO_BITS(NARROW_LO_BITS)) i_core (
    .clk(clk), .rst(rst), .tick(tick), .width(width),
    .lo_we(lo_we), .lo_wdata(lo_wdata), .hi_we(hi_we), .hi_wdata(hi_wdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .vec_ack(vec_ack),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int BYTE_W         = 8,
  parameter int NARROW_LO_BITS = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic              src_ext,
  input logic              gate_en,
  input logic              wide_mode,
  input logic              lo_we,
  input logic [BYTE_W-1:0] lo_wdata,
  input logic              hi_we,
  input logic [BYTE_W-1:0] hi_wdata,
  input logic              flag_we,
  input logic              flag_wdata,
  input logic              vec_ack,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic              ovf_flag,
  input logic              ovf_pulse
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt_lo == '0 && cnt_hi == '0 && !ovf_flag && !ovf_pulse));

  // R2
  clock_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en && !src_ext && !gate_en && wide_mode && !lo_we && !hi_we)
      |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + (2*BYTE_W)'(1)));

  // R3
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !lo_we && !hi_we) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> !ovf_pulse);

  // R8
  pulse_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> (cnt_hi == '0 &&
                   (wide_mode ? (cnt_lo == '0) : (cnt_lo[NARROW_LO_BITS-1:0] == '0))));

  // R8
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_pulse && !$past(flag_we)) |-> ovf_flag);

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_ack && !flag_we) |=> (ovf_flag == ovf_pulse));

  // R10
  flag_write_chk: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> (ovf_flag == $past(flag_wdata)));

  // R11
  lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> (cnt_lo == $past(lo_wdata)));

  // R11
  hi_write_chk: assert property (@(posedge clk) disable iff (rst)
    hi_we |=> (cnt_hi == $past(hi_wdata)));

  // R11
  lo_kept_on_hi_write_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_we && !lo_we) |=> $stable(cnt_lo));
endmodule

bind dual_mode_timer tmr_checker #(
  .BYTE_W(BYTE_W), .NARROW_LO_BITS(NARROW_LO_BITS)
) i_tmr_checker (
  .clk(clk), .rst(rst), .run_en(run_en), .src_ext(src_ext), .gate_en(gate_en),
  .wide_mode(wide_mode), .lo_we(lo_we), .lo_wdata(lo_wdata), .hi_we(hi_we),
  .hi_wdata(hi_wdata), .flag_we(flag_we), .flag_wdata(flag_wdata),
  .vec_ack(vec_ack), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag),
  .ovf_pulse(ovf_pulse)
);

// File: tb/test_dual_mode_timer.sv
module test_dual_mode_timer;
  logic       clk = 1'b0;
  logic       rst;
  logic       run_en, src_ext, gate_en, irq_n, cnt_pin, wide_mode;
  logic       lo_we, hi_we, flag_we, flag_wdata, vec_ack;
  logic [7:0] lo_wdata, hi_wdata;
  logic [7:0] cnt_lo, cnt_hi;
  logic       ovf_flag, ovf_pulse;

  int tests  = 0;
  int failed = 0;

  always #10 clk = ~clk;

  dual_mode_timer i_dual_mode_timer (
    .clk(clk), .rst(rst), .run_en(run_en), .src_ext(src_ext), .gate_en(gate_en),
    .irq_n(irq_n), .cnt_pin(cnt_pin), .wide_mode(wide_mode),
    .lo_we(lo_we), .lo_wdata(lo_wdata), .hi_we(hi_we), .hi_wdata(hi_wdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .vec_ack(vec_ack),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] hi, input logic [7:0] lo);
    hi_we = 1'b1; hi_wdata = hi; lo_we = 1'b1; lo_wdata = lo;
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0;
  endtask

  task automatic run_for(input int n);
    run_en = 1'b1;
    tick_n(n);
    run_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failed++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    int k;
    rst = 1'b1; run_en = 0; src_ext = 0; gate_en = 0; irq_n = 1; cnt_pin = 1;
    wide_mode = 0; lo_we = 0; hi_we = 0; lo_wdata = 0; hi_wdata = 0;
    flag_we = 0; flag_wdata = 0; vec_ack = 0;
    tick_n(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", {cnt_hi, cnt_lo}, 0);
    chk("R1 flag/pulse", {ovf_flag, ovf_pulse}, 0);

    // R2 R6 R8: full 13-bit sweep, upper low-byte bits preset to 111
    wide_mode = 0;
    load(8'h00, 8'hE0);
    run_en = 1'b1;
    for (int i = 1; i <= 8195; i++) begin
      int e;
      @(negedge clk);
      e = i % 8192;
      chk("R2 R6 13-bit count", {cnt_hi, cnt_lo[4:0]}, e);
      if (i == 1 || i == 8192) chk("R6 upper low bits kept", cnt_lo[7:5], 3'b111);
      chk("R8 pulse", ovf_pulse, (e == 0));
      chk("R8 flag", ovf_flag, (i >= 8192));
    end
    run_en = 1'b0;

    // R9 ack clears flag
    vec_ack = 1'b1; @(negedge clk); vec_ack = 1'b0;
    chk("R9 ack clear", ovf_flag, 0);

    // R3 hold while stopped
    k = {cnt_hi, cnt_lo};
    tick_n(10);
    chk("R3 hold", {cnt_hi, cnt_lo}, k);

    // R7 16-bit wrap and carry
    wide_mode = 1;
    load(8'hFF, 8'hF0);
    run_en = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      chk("R7 16-bit count", {cnt_hi, cnt_lo}, (32'hFFF0 + i) & 32'hFFFF);
      chk("R8 pulse 16", ovf_pulse, (i == 16));
    end
    run_en = 1'b0;
    load(8'h12, 8'hFC);
    run_for(6);
    chk("R7 carry", {cnt_hi, cnt_lo}, 16'h1302);

    // R11 byte write cancels increment
    load(8'h34, 8'h10);
    run_en = 1'b1;
    tick_n(2);
    lo_we = 1'b1; lo_wdata = 8'h40;
    @(negedge clk);
    lo_we = 1'b0;
    chk("R11 lo write wins", {cnt_hi, cnt_lo}, 16'h3440);
    @(negedge clk);
    chk("R11 resume", {cnt_hi, cnt_lo}, 16'h3441);
    hi_we = 1'b1; hi_wdata = 8'h77;
    @(negedge clk);
    hi_we = 1'b0;
    chk("R11 hi write, lo kept", {cnt_hi, cnt_lo}, 16'h7741);
    run_en = 1'b0;

    // R9 wrap beats ack in the same cycle
    flag_we = 1'b1; flag_wdata = 1'b1;
    load(8'hFF, 8'hFF);
    flag_we = 1'b0;
    run_en = 1'b1; vec_ack = 1'b1;
    @(negedge clk);
    run_en = 1'b0; vec_ack = 1'b0;
    chk("R9 set beats ack flag", ovf_flag, 1);
    chk("R9 wrap pulse", ovf_pulse, 1);

    // R10 flag write beats wrap
    load(8'hFF, 8'hFF);
    run_en = 1'b1; flag_we = 1'b1; flag_wdata = 1'b0;
    @(negedge clk);
    run_en = 1'b0; flag_we = 1'b0;
    chk("R10 write beats wrap", ovf_flag, 0);
    chk("R10 pulse still", ovf_pulse, 1);
    chk("R10 count zero", {cnt_hi, cnt_lo}, 0);
    flag_we = 1'b1; flag_wdata = 1'b1; vec_ack = 1'b1;
    @(negedge clk);
    flag_we = 1'b0; vec_ack = 1'b0;
    chk("R10 write beats ack", ovf_flag, 1);

    // R5 gate behaviour (irq_n changed only while stopped)
    load(8'h00, 8'h00);
    gate_en = 1'b1; irq_n = 1'b0; tick_n(4);
    run_for(10);
    chk("R5 gate closed", {cnt_hi, cnt_lo}, 0);
    irq_n = 1'b1; tick_n(4);
    run_for(10);
    chk("R5 gate open", {cnt_hi, cnt_lo}, 10);
    gate_en = 1'b0; irq_n = 1'b0; tick_n(4);
    run_for(7);
    chk("R5 gate disabled", {cnt_hi, cnt_lo}, 17);
    irq_n = 1'b1; tick_n(4);

    // R4 event counting on falling edges
    src_ext = 1'b1; cnt_pin = 1'b1;
    load(8'h00, 8'h00);
    tick_n(4);
    run_en = 1'b1;
    tick_n(10);
    chk("R4 no clock counting", {cnt_hi, cnt_lo}, 0);
    k = 0;
    for (int w = 1; w <= 3; w++) begin
      for (int p = 0; p < 4; p++) begin
        cnt_pin = 1'b0; tick_n(w);
        cnt_pin = 1'b1; tick_n(2);
        k++;
      end
    end
    tick_n(5);
    chk("R4 pulse count", {cnt_hi, cnt_lo}, k);
    cnt_pin = 1'b0; tick_n(20);
    chk("R4 low level counts once", {cnt_hi, cnt_lo}, k + 1);
    cnt_pin = 1'b1; tick_n(20);
    chk("R4 rise ignored", {cnt_hi, cnt_lo}, k + 1);
    gate_en = 1'b1; irq_n = 1'b0; run_en = 1'b0; tick_n(4); run_en = 1'b1;
    cnt_pin = 1'b0; tick_n(3); cnt_pin = 1'b1; tick_n(5);
    chk("R4 R5 gated event", {cnt_hi, cnt_lo}, k + 1);
    run_en = 1'b0;

    // R1 reset again from non-zero state
    flag_we = 1'b1; flag_wdata = 1'b1; @(negedge clk); flag_we = 1'b0;
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 reset clears", {cnt_hi, cnt_lo, 6'b0, ovf_flag, ovf_pulse}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule